// File: doc/BRIEF.md
# SM4 Four-Round Cipher Engine

This block advances a 128-bit SM4 state by four chained rounds. The state is four 32-bit words, and the four rounds use four 32-bit round keys or schedule constants. A single mode bit picks one of two flavours that share the whole datapath. In the schedule flavour, the block turns a four-word key window into the next four round keys. In the encryption flavour, the block pushes a data block four rounds forward. The two flavours differ only in the linear diffusion that follows the byte substitution.

An operand vector carries one or two independent 128-bit lanes. One round engine handles all of them: a byte-wise S-box followed by the selected diffusion. It completes one round per clock, lane 0 first and then lane 1. Operands come in over a valid/ready handshake. The mode and the lane count are latched when the operands are accepted. The packed result stays on the output until it is taken.

Top module: `sm4r_quad`

## Requirements
- R1: The substitution replaces each byte of its 32-bit input in place, using the fixed 256-entry SM4 S-box. Three of its values are 0x00→0xD6, 0x01→0x90 and 0xFF→0x48.
- R2: With in_mode = 0 (schedule flavour), the diffusion is D(x) = x ^ rotl(x,13) ^ rotl(x,23).
- R3: With in_mode = 1 (encryption flavour), the diffusion is D(x) = x ^ rotl(x,2) ^ rotl(x,10) ^ rotl(x,18) ^ rotl(x,24).
- R4: Word layout and round order:
  - Word i of lane n sits at bits [(4n+i)*32 +: 32] of in_state, in_keys and out_data.
  - One round gives F(a,b,c,d,k) = a ^ D(S(b^c^d^k)).
  - The outputs are C0=F(P0,P1,P2,P3,K0), C1=F(P1,P2,P3,C0,K1), C2=F(P2,P3,C0,C1,K2) and C3=F(P3,C0,C1,C2,K3).
  - Ci is placed at word i of its lane.
- R5: With in_wide = 1, both lanes are processed, and each lane uses only its own state and key words.
- R6: With in_wide = 0, only lane 0 is computed, and out_data bits 255:128 are zero.
- R7: out_valid rises exactly 4 clock edges after the accepting edge for one lane, and exactly 8 edges after it for two lanes.
- R8: While out_valid = 1 and out_ready = 0, out_valid stays high and out_data does not change.
- R9: Handshake:
  - After reset, in_ready = 1 and out_valid = 0.
  - in_ready is 0 from the cycle after an accept until the cycle after the result is taken (out_valid & out_ready).
  - in_ready and out_valid are never high together.
- R10: in_mode and in_wide are sampled only on the accepting edge. Changing them later has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Engine idle, operands will be taken |
| in_mode | input | 1 | 0 = schedule diffusion, 1 = encryption diffusion |
| in_wide | input | 1 | 0 = one lane, 1 = two lanes |
| in_state | input | 256 | State words P0..P3 for each lane |
| in_keys | input | 256 | Round keys K0..K3 for each lane |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Result words C0..C3 for each lane, unused lane zero |

## Verification
Each round shifts its word into the four-word window that feeds the next round. A wrong S-box entry or a wrong rotation therefore shows up in word 0 of a lane, and then spreads into every later word of that lane. Both flavours are checked against published schedule and encryption values. A window that is loaded from the wrong lane, or a key index that is off by one, corrupts lane 1 only. A bad round or lane counter moves the rise of out_valid away from edge 4 or edge 8. A bad handshake flag shows up on in_ready within one cycle after the accept or after the result is taken.

// File: rtl/sm4r_pkg.sv
package sm4r_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_WORDS = 4;
    localparam int LANE_W = WORD_W * LANE_WORDS;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_SCHED = 1'b0,
        MODE_ENC   = 1'b1
    } mode_e;

    // Substitution table, stored as four 64-byte quarters, byte 0 at the top.
    localparam logic [511:0] SBOX_Q0 = {
        128'hD690E9FECCE13DB716B614C228FB2C05, 128'h2B679A762ABE04C3AA44132649860699,
        128'h9C4250F491EF987A33540B43EDCFAC62, 128'hE4B31CA9C908E89580DF94FA758F3FA6};
    localparam logic [511:0] SBOX_Q1 = {
        128'h4707A7FCF37317BA83593C19E6854FA8, 128'h686B81B27164DA8BF8EB0F4B70569D35,
        128'h1E240E5E6358D1A225227C3B01217887, 128'hD40046579FD327524C3602E7A0C4C89E};
    localparam logic [511:0] SBOX_Q2 = {
        128'hEABF8AD240C738B5A3F7F2CEF96115A1, 128'hE0AE5DA49B341A55AD933230F58CB1E3,
        128'h1DF6E22E8266CA60C02923AB0D534E6F, 128'hD5DB3745DEFD8E2F03FF6A726D6C5B51};
    localparam logic [511:0] SBOX_Q3 = {
        128'h8D1BAF92BBDDBC7F11D95C411F105AD8, 128'h0AC13188A5CD7BBD2D74D012B8E5B4B0,
        128'h8969974A0C96777E65B9F109C56EC684, 128'h18F07DEC3ADC4D2079EE5F3ED7CB3948};

    function automatic logic [7:0] sbox_byte(input logic [7:0] b);
        logic [511:0] quarter;
        case (b[7:6])
            2'd0:    quarter = SBOX_Q0;
            2'd1:    quarter = SBOX_Q1;
            2'd2:    quarter = SBOX_Q2;
            default: quarter = SBOX_Q3;
        endcase
        return quarter[(63 - int'(b[5:0])) * 8 +: 8];
    endfunction

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

endpackage

// File: rtl/sm4r_sbox_word.sv
module sm4r_sbox_word
    import sm4r_pkg::*;
(
    input  word_t din,
    output word_t dout
);
    localparam int NBYTES = WORD_W / 8;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign dout[g*8 +: 8] = sbox_byte(din[g*8 +: 8]);
    end

endmodule

// File: rtl/sm4r_diffuse.sv
module sm4r_diffuse
    import sm4r_pkg::*;
(
    input  logic  mode,
    input  word_t din,
    output word_t dout
);
    word_t sched_w;
    word_t enc_w;

    always_comb begin
        sched_w = din ^ rotl(din, 13) ^ rotl(din, 23);
        enc_w   = din ^ rotl(din, 2) ^ rotl(din, 10) ^ rotl(din, 18) ^ rotl(din, 24);
        dout    = (mode == MODE_ENC) ? enc_w : sched_w;
    end

endmodule

// File: rtl/sm4r_round.sv
module sm4r_round
    import sm4r_pkg::*;
(
    input  logic  mode,
    input  word_t x0,
    input  word_t x1,
    input  word_t x2,
    input  word_t x3,
    input  word_t rk,
    output word_t nw
);
    word_t mix_w;
    word_t sub_w;
    word_t lin_w;

    assign mix_w = x1 ^ x2 ^ x3 ^ rk;

    sm4r_sbox_word u_sbox (
        .din  (mix_w),
        .dout (sub_w)
    );

    sm4r_diffuse u_diff (
        .mode (mode),
        .din  (sub_w),
        .dout (lin_w)
    );

    assign nw = x0 ^ lin_w;

endmodule

// File: rtl/sm4r_quad.sv
module sm4r_quad
    import sm4r_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_mode,
    input  logic                    in_wide,
    input  logic [LANES*LANE_W-1:0] in_state,
    input  logic [LANES*LANE_W-1:0] in_keys,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*LANE_W-1:0] out_data
);
    localparam int VEC_W = LANES * LANE_W;
    localparam int LIW   = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic                  busy;
        logic                  done;
        logic                  mode;
        logic [LIW-1:0]        last;
        logic [LIW-1:0]        lane;
        logic [1:0]            rnd;
        logic [3:0][WORD_W-1:0] win;
        logic [VEC_W-1:0]      src;
        logic [VEC_W-1:0]      key;
        logic [VEC_W-1:0]      res;
    } eng_t;

    eng_t  s_d, s_q;
    word_t rk_w;
    word_t nw_w;
    logic  accept_w;
    logic  consume_w;

    assign rk_w = s_q.key[(int'(s_q.lane) * LANE_WORDS + int'(s_q.rnd)) * WORD_W +: WORD_W];

    sm4r_round u_round (
        .mode (s_q.mode),
        .x0   (s_q.win[0]),
        .x1   (s_q.win[1]),
        .x2   (s_q.win[2]),
        .x3   (s_q.win[3]),
        .rk   (rk_w),
        .nw   (nw_w)
    );

    assign in_ready  = !s_q.busy && !s_q.done;
    assign out_valid = s_q.done;
    assign out_data  = s_q.res;
    assign accept_w  = in_valid && in_ready;
    assign consume_w = s_q.done && out_ready;

    always_comb begin
        s_d = s_q;
        if (accept_w) begin
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
            s_d.mode = in_mode;
            s_d.last = in_wide ? LIW'(LANES - 1) : '0;
            s_d.lane = '0;
            s_d.rnd  = 2'd0;
            s_d.src  = in_state;
            s_d.key  = in_keys;
            s_d.res  = '0;
            for (int i = 0; i < LANE_WORDS; i++) begin
                s_d.win[i] = in_state[i*WORD_W +: WORD_W];
            end
        end else if (s_q.busy) begin
            s_d.res[(int'(s_q.lane) * LANE_WORDS + int'(s_q.rnd)) * WORD_W +: WORD_W] = nw_w;
            s_d.win[0] = s_q.win[1];
            s_d.win[1] = s_q.win[2];
            s_d.win[2] = s_q.win[3];
            s_d.win[3] = nw_w;
            if (s_q.rnd == 2'd3) begin
                if (s_q.lane == s_q.last) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.lane = s_q.lane + 1'b1;
                    s_d.rnd  = 2'd0;
                    for (int i = 0; i < LANE_WORDS; i++) begin
                        s_d.win[i] = s_q.src[((int'(s_q.lane) + 1) * LANE_WORDS + i) * WORD_W +: WORD_W];
                    end
                end
            end else begin
                s_d.rnd = s_q.rnd + 2'd1;
            end
        end
        if (consume_w) begin
            s_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/sm4r_quad_chk.sv
module sm4r_quad_chk #(
    parameter int LANES = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  in_wide,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [LANES*128-1:0]  out_data
);
    localparam int VEC_W = LANES * 128;

    logic       pend_q;
    logic       wide_q;
    logic [7:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            wide_q <= 1'b0;
            cnt_q  <= 8'd0;
        end else if (in_valid && in_ready) begin
            pend_q <= 1'b1;
            wide_q <= in_wide;
            cnt_q  <= 8'd0;
        end else if (pend_q && !out_valid) begin
            cnt_q  <= cnt_q + 8'd1;
        end else if (out_valid) begin
            pend_q <= 1'b0;
        end
    end

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pend_q) |-> (cnt_q == (wide_q ? 8'(4 * LANES) : 8'd4)));

    if (LANES > 1) begin : g_upper
        p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !wide_q) |-> (out_data[VEC_W-1:128] == '0));
    end

endmodule

bind sm4r_quad sm4r_quad_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_wide   (in_wide),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sm4r_quad_bench.sv
module sm4r_quad_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_mode = 1'b0;
    logic         in_wide = 1'b0;
    logic [255:0] in_state = '0;
    logic [255:0] in_keys = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [255:0] out_data;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sm4r_quad u_sm4r_quad (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_wide(in_wide), .in_state(in_state), .in_keys(in_keys),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction
    function automatic logic [31:0] d_sched(input logic [31:0] x);
        return x ^ rl(x, 13) ^ rl(x, 23);
    endfunction
    function automatic logic [31:0] d_enc(input logic [31:0] x);
        return x ^ rl(x, 2) ^ rl(x, 10) ^ rl(x, 18) ^ rl(x, 24);
    endfunction
    function automatic logic [127:0] lane4(input logic [31:0] w0, w1, w2, w3);
        return {w3, w2, w1, w0};
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one operation; checks handshake, latency, hold and ignored late mode changes.
    task automatic run_op(input logic mode, input logic wide, input logic [255:0] st,
                          input logic [255:0] ky, input int stall, output logic [255:0] res);
        int cnt;
        logic [255:0] held;
        @(negedge clk);
        in_valid = 1'b1; in_mode = mode; in_wide = wide; in_state = st; in_keys = ky;
        @(negedge clk);
        in_valid = 1'b0;
        in_mode = ~mode;            // R10: late change must be ignored
        in_wide = ~wide;
        in_state = ~st;
        chk("R9 ready low after accept", {255'd0, in_ready}, 256'd0);
        cnt = 0;
        while (!out_valid && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        chk("R7 latency", 256'(cnt), wide ? 256'd8 : 256'd4);
        held = out_data;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk("R8 hold data", out_data, held);
            chk("R8 hold valid", {255'd0, out_valid}, 256'd1);
        end
        res = out_data;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R9 valid drops after take", {255'd0, out_valid}, 256'd0);
        chk("R9 ready back", {255'd0, in_ready}, 256'd1);
    endtask

    task automatic t_reset;
        chk("R9 reset in_ready", {255'd0, in_ready}, 256'd1);
        chk("R9 reset out_valid", {255'd0, out_valid}, 256'd0);
    endtask

    // R2 R4 R6 R10: schedule flavour, published first four round keys
    task automatic t_sched_vector;
        logic [255:0] r;
        run_op(1'b0, 1'b0,
            {128'd0, lane4(32'hA292FFA1, 32'hDF01FEBF, 32'h99A12B0F, 32'hC42410CC)},
            {128'd0, lane4(32'h00070E15, 32'h1C232A31, 32'h383F464D, 32'h545B6269)}, 3, r);
        chk("R2 R4 schedule lane0", {128'd0, r[127:0]},
            {128'd0, lane4(32'hF12186F9, 32'h41662B61, 32'h5A6AB19A, 32'h7BA92077)});
        chk("R6 upper zero", {128'd0, r[255:128]}, 256'd0);
    endtask

    // R3 R4: encryption flavour, published first four round outputs
    task automatic t_enc_vector;
        logic [255:0] r;
        run_op(1'b1, 1'b0,
            {128'd0, lane4(32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210)},
            {128'd0, lane4(32'hF12186F9, 32'h41662B61, 32'h5A6AB19A, 32'h7BA92077)}, 0, r);
        chk("R3 R4 encryption lane0", r,
            {128'd0, lane4(32'h27FAD345, 32'hA18B4CB2, 32'h11C1E22A, 32'hCC13E2EE)});
    endtask

    // R1 R5: S-box probes through word 0 of each lane
    task automatic t_sbox_probes;
        logic [255:0] r;
        run_op(1'b1, 1'b0, 256'd0, 256'd0, 1, r);
        chk("R1 sbox 00 enc", {224'd0, r[31:0]}, {224'd0, d_enc(32'hD6D6D6D6)});
        run_op(1'b0, 1'b0, 256'd0, 256'd0, 0, r);
        chk("R1 sbox 00 sched", {224'd0, r[31:0]}, {224'd0, d_sched(32'hD6D6D6D6)});
        run_op(1'b1, 1'b1,
            {lane4(32'h0, 32'hFFFFFFFF, 32'h0, 32'h0), lane4(32'h0, 32'h01010101, 32'h0, 32'h0)},
            256'd0, 2, r);
        chk("R1 sbox 01 lane0", {224'd0, r[31:0]}, {224'd0, d_enc(32'h90909090)});
        chk("R1 R5 sbox FF lane1", {224'd0, r[159:128]}, {224'd0, d_enc(32'h48484848)});
    endtask

    // R5: two lanes of the schedule, lane1 continues from lane0's result
    task automatic t_two_lane_sched;
        logic [255:0] r;
        run_op(1'b0, 1'b1,
            {lane4(32'hF12186F9, 32'h41662B61, 32'h5A6AB19A, 32'h7BA92077),
             lane4(32'hA292FFA1, 32'hDF01FEBF, 32'h99A12B0F, 32'hC42410CC)},
            {lane4(32'h70777E85, 32'h8C939AA1, 32'hA8AFB6BD, 32'hC4CBD2D9),
             lane4(32'h00070E15, 32'h1C232A31, 32'h383F464D, 32'h545B6269)}, 2, r);
        chk("R5 two-lane schedule", r,
            {lane4(32'h367360F4, 32'h776A0C61, 32'hB6BB89B3, 32'h24763151),
             lane4(32'hF12186F9, 32'h41662B61, 32'h5A6AB19A, 32'h7BA92077)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sched_vector();
        t_enc_vector();
        t_sbox_probes();
        t_two_lane_sched();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule